// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor core whose storage is a ring of overlapping register windows plus a bank of globals. Each instruction addresses 32 logical registers through 5-bit names. A current-window pointer turns each name into a physical slot. Names 1 to 7 reach a global bank that every window shares. An alternate-globals select swaps in a second bank of seven usable globals, for example while a trap handler runs. The other 24 names reach the current window's incoming, local and outgoing registers.

Each window owns 16 physical registers: 8 incoming and 8 local. Its 8 outgoing registers are the same storage as the incoming registers of the neighbouring window. A save strobe moves the pointer one step down and a restore strobe moves it one step up. After a save, the values the caller left in its outgoing registers appear in the callee's incoming registers, with no copy made. A mask input marks windows that are not resident. A rotation onto a marked window is refused and flagged, so that trap logic outside this block can spill or fill it. There are two combinational read ports and one write port that commits on the clock edge. The window count is a parameter from 3 to 32. Registers are 64 bits wide.

Top module: `rwin_regfile`

## Requirements
- R1: While `rst` is high and after it falls, `cwp` is 0, `ovf` and `unf` are 0, and every logical register reads 0 until written.
- R2: Logical register 0 always reads 0 on both read ports. A write to it has no effect on any register.
- R3: A write commits on the rising clock edge. Reads are combinational from the current state. A read of the register being written in the same cycle returns the old value.
- R4: A save alone decrements `cwp` modulo NWIN (0 wraps to NWIN-1) on the clock edge. A restore alone increments it modulo NWIN (NWIN-1 wraps to 0).
- R5: If a save alone targets a window whose bit in `win_invalid` is 1, `ovf` is 1 in that same cycle and `cwp` does not change. Otherwise `ovf` is 0.
- R6: If a restore alone targets a window whose bit in `win_invalid` is 1, `unf` is 1 in that same cycle and `cwp` does not change. Otherwise `unf` is 0.
- R7: When `save_req` and `restore_req` are both 1, `cwp` does not change and neither flag is raised.
- R8: Logical 8–15 (outgoing) of window w are the same storage as logical 24–31 (incoming) of window w-1 mod NWIN.
- R9: Logical 16–23 (locals) are private to each window. A local written in one window is not seen from any other window.
- R10: Logical 1–7 reach the normal global bank in every window when `alt_glob` is 0, and a separate alternate bank when `alt_glob` is 1. Both reads and writes follow `alt_glob`.
- R11: A write issued in the same cycle as a save or restore uses the mapping of the window that was current before the rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rs1_addr | input | 5 | Logical address, read port 1 |
| rs1_data | output | 64 | Read data, port 1 (combinational) |
| rs2_addr | input | 5 | Logical address, read port 2 |
| rs2_data | output | 64 | Read data, port 2 (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical write address |
| wr_data | input | 64 | Write data |
| save_req | input | 1 | Rotate to the next window down |
| restore_req | input | 1 | Rotate to the next window up |
| alt_glob | input | 1 | Steer logical 1–7 to the alternate globals |
| win_invalid | input | NWIN | One bit per window, 1 = rotation onto it is refused |
| cwp | output | $clog2(NWIN) | Current window pointer |
| ovf | output | 1 | Save refused (window overflow) |
| unf | output | 1 | Restore refused (window underflow) |

## Verification
The bench goes after the corners that break a windowed file in subtle ways:
- **Pointer wrap.** A design with wrong wrap arithmetic lands on a window outside the ring after a save from window 0 or a restore from the top window.
- **Overlap direction.** A design that aliases outs to the wrong neighbour loses the arguments after a save.
- **Write during rotation.** A design that applies the post-rotation mapping to a write issued with a save puts the value in the wrong window.
- **Refused rotation.** A design that rotates anyway, or raises the flag on the wrong neighbour's mask bit, drifts away from the model.
- **Register 0.** A design that stores writes to register 0 returns them on a read.
- **Alternate globals.** A design that ignores `alt_glob` on writes mixes the two banks.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int XLEN     = 64;
    localparam int NGLOB    = 8;
    localparam int WIN_REGS = 16;
    localparam int HALF     = 8;

    // Logical segment selected by address bits [4:3]
    typedef enum logic [1:0] {
        SEG_GLOB = 2'd0,
        SEG_OUT  = 2'd1,
        SEG_LOC  = 2'd2,
        SEG_IN   = 2'd3
    } seg_e;

    // Outcome of a rotation request for one cycle
    typedef struct packed {
        logic move;
        logic ovf;
        logic unf;
    } rot_t;

    function automatic seg_e seg_of(logic [4:0] a);
        return seg_e'(a[4:3]);
    endfunction

    function automatic int unsigned wrap_dec(int unsigned w, int unsigned nwin);
        return (w == 0) ? nwin - 1 : w - 1;
    endfunction

    function automatic int unsigned wrap_inc(int unsigned w, int unsigned nwin);
        return (w == nwin - 1) ? 0 : w + 1;
    endfunction

    // Physical layout: normal globals [0..7], alternate globals [8..15],
    // then window w occupies 16 slots: ins first, locals next.
    function automatic int unsigned win_base(int unsigned w);
        return 2 * NGLOB + WIN_REGS * w;
    endfunction

    function automatic int unsigned map_phys(logic [4:0] a, int unsigned cwp,
                                             logic alt, int unsigned nwin);
        int unsigned base;
        case (seg_of(a))
            SEG_GLOB: base = alt ? NGLOB : 0;
            SEG_OUT:  base = win_base(wrap_dec(cwp, nwin));
            SEG_LOC:  base = win_base(cwp) + HALF;
            SEG_IN:   base = win_base(cwp);
            default:  base = 0;
        endcase
        return base + 32'(a[2:0]);
    endfunction

endpackage

// File: rtl/rwin_ptr.sv
module rwin_ptr
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic [NWIN-1:0] win_invalid,
    output logic [CWPW-1:0] cwp,
    output logic            ovf,
    output logic            unf
);

    logic [CWPW-1:0] cwp_q;
    logic [CWPW-1:0] cwp_dn;
    logic [CWPW-1:0] cwp_up;
    logic            save_only;
    logic            rest_only;
    rot_t            rot;

    assign cwp_dn    = CWPW'(wrap_dec(32'(cwp_q), NWIN));
    assign cwp_up    = CWPW'(wrap_inc(32'(cwp_q), NWIN));
    assign save_only = save_req & ~restore_req;
    assign rest_only = restore_req & ~save_req;

    always_comb begin
        rot.ovf  = save_only & win_invalid[cwp_dn];
        rot.unf  = rest_only & win_invalid[cwp_up];
        rot.move = (save_only | rest_only) & ~rot.ovf & ~rot.unf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp_q <= '0;
        end else if (rot.move) begin
            cwp_q <= save_only ? cwp_dn : cwp_up;
        end
    end

    assign cwp = cwp_q;
    assign ovf = rot.ovf;
    assign unf = rot.unf;

endmodule

// File: rtl/rwin_map.sv
module rwin_map
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CWPW  = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int DEPTH = 2 * NGLOB + WIN_REGS * NWIN,
    localparam int PIW   = $clog2(DEPTH)
) (
    input  logic [4:0]      laddr,
    input  logic [CWPW-1:0] cwp,
    input  logic            alt,
    output logic            is_zero,
    output logic [PIW-1:0]  paddr
);

    assign is_zero = (laddr == 5'd0);
    assign paddr   = PIW'(map_phys(laddr, 32'(cwp), alt, NWIN));

endmodule

// File: rtl/rwin_store.sv
module rwin_store
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int NRD  = 2,
    localparam int DEPTH = 2 * NGLOB + WIN_REGS * NWIN,
    localparam int PIW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic                      wr_zero,
    input  logic [PIW-1:0]            wr_idx,
    input  logic [XLEN-1:0]           wr_val,
    input  logic [NRD-1:0]            rd_zero,
    input  logic [NRD-1:0][PIW-1:0]   rd_idx,
    output logic [NRD-1:0][XLEN-1:0]  rd_val
);

    logic [XLEN-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we && !wr_zero) begin
            mem[wr_idx] <= wr_val;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_val[g] = rd_zero[g] ? '0 : mem[rd_idx[g]];
    end

endmodule

// File: rtl/rwin_regfile.sv
module rwin_regfile
    import rwin_pkg::*;
#(
    parameter int NWIN = 8,
    localparam int CWPW  = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int DEPTH = 2 * NGLOB + WIN_REGS * NWIN,
    localparam int PIW   = $clog2(DEPTH),
    localparam int NPORT = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [4:0]      rs1_addr,
    output logic [63:0]     rs1_data,
    input  logic [4:0]      rs2_addr,
    output logic [63:0]     rs2_data,
    input  logic            wr_en,
    input  logic [4:0]      wr_addr,
    input  logic [63:0]     wr_data,
    input  logic            save_req,
    input  logic            restore_req,
    input  logic            alt_glob,
    input  logic [NWIN-1:0] win_invalid,
    output logic [CWPW-1:0] cwp,
    output logic            ovf,
    output logic            unf
);

    logic [CWPW-1:0]            cwp_cur;
    logic [NPORT-1:0][4:0]      laddr;
    logic [NPORT-1:0]           pzero;
    logic [NPORT-1:0][PIW-1:0]  pidx;
    logic [1:0][XLEN-1:0]       rdv;

    // Port order: 0 = read 1, 1 = read 2, 2 = write
    assign laddr = {wr_addr, rs2_addr, rs1_addr};

    rwin_ptr #(.NWIN(NWIN)) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .save_req    (save_req),
        .restore_req (restore_req),
        .win_invalid (win_invalid),
        .cwp         (cwp_cur),
        .ovf         (ovf),
        .unf         (unf)
    );

    // Mapping uses the pre-rotation pointer for every port
    for (genvar p = 0; p < NPORT; p++) begin : g_map
        rwin_map #(.NWIN(NWIN)) u_map (
            .laddr   (laddr[p]),
            .cwp     (cwp_cur),
            .alt     (alt_glob),
            .is_zero (pzero[p]),
            .paddr   (pidx[p])
        );
    end

    rwin_store #(.NWIN(NWIN), .NRD(2)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .wr_zero (pzero[2]),
        .wr_idx  (pidx[2]),
        .wr_val  (wr_data),
        .rd_zero (pzero[1:0]),
        .rd_idx  (pidx[1:0]),
        .rd_val  (rdv)
    );

    assign rs1_data = rdv[0];
    assign rs2_data = rdv[1];
    assign cwp      = cwp_cur;

endmodule

// File: rtl/rwin_regfile_chk.sv
module rwin_regfile_chk #(
    parameter int NWIN = 8,
    localparam int CWPW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
    input logic            clk,
    input logic            rst,
    input logic [4:0]      rs1_addr,
    input logic [63:0]     rs1_data,
    input logic [4:0]      rs2_addr,
    input logic [63:0]     rs2_data,
    input logic            save_req,
    input logic            restore_req,
    input logic [CWPW-1:0] cwp,
    input logic            ovf,
    input logic            unf
);

    function automatic logic [CWPW-1:0] step_dn(logic [CWPW-1:0] w);
        return (w == 0) ? CWPW'(NWIN - 1) : w - 1'b1;
    endfunction

    function automatic logic [CWPW-1:0] step_up(logic [CWPW-1:0] w);
        return (w == CWPW'(NWIN - 1)) ? '0 : w + 1'b1;
    endfunction

    a_r2_zero_rs1: assert property (@(posedge clk) disable iff (rst)
        (rs1_addr == 5'd0) |-> (rs1_data == 64'd0));

    a_r2_zero_rs2: assert property (@(posedge clk) disable iff (rst)
        (rs2_addr == 5'd0) |-> (rs2_data == 64'd0));

    a_r4_save_step: assert property (@(posedge clk) disable iff (rst)
        (save_req && !restore_req && !ovf) |=> (cwp == step_dn($past(cwp))));

    a_r4_restore_step: assert property (@(posedge clk) disable iff (rst)
        (restore_req && !save_req && !unf) |=> (cwp == step_up($past(cwp))));

    a_r5_ovf_hold: assert property (@(posedge clk) disable iff (rst)
        ovf |=> $stable(cwp));

    a_r5_ovf_cause: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (save_req && !restore_req));

    a_r6_unf_hold: assert property (@(posedge clk) disable iff (rst)
        unf |=> $stable(cwp));

    a_r6_unf_cause: assert property (@(posedge clk) disable iff (rst)
        unf |-> (restore_req && !save_req));

    a_r7_both_idle: assert property (@(posedge clk) disable iff (rst)
        (save_req && restore_req) |=> $stable(cwp));

    a_r1_reset_ptr: assert property (@(posedge clk)
        rst |=> (cwp == '0));

endmodule

bind rwin_regfile rwin_regfile_chk #(.NWIN(NWIN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rs1_addr    (rs1_addr),
    .rs1_data    (rs1_data),
    .rs2_addr    (rs2_addr),
    .rs2_data    (rs2_data),
    .save_req    (save_req),
    .restore_req (restore_req),
    .cwp         (cwp),
    .ovf         (ovf),
    .unf         (unf)
);

// File: tb/rwin_regfile_tb.sv
module rwin_regfile_tb_top;

    localparam int NW   = 8;
    localparam int CW   = $clog2(NW);
    localparam int NRND = 3000;

    logic          clk = 1'b0;
    logic          rst;
    logic [4:0]    rs1_addr, rs2_addr, wr_addr;
    logic [63:0]   rs1_data, rs2_data, wr_data;
    logic          wr_en, save_req, restore_req, alt_glob;
    logic [NW-1:0] win_invalid;
    logic [CW-1:0] cwp;
    logic          ovf, unf;

    int   n_checks = 0;
    int   n_errors = 0;
    logic done     = 1'b0;

    // Reference model state
    int          m_cwp;
    logic [63:0] m_glob [8];
    logic [63:0] m_alt  [8];
    logic [63:0] m_in   [NW][8];
    logic [63:0] m_loc  [NW][8];

    // Last sampled outputs
    logic [63:0] s_rd1, s_rd2;
    logic [CW-1:0] s_cwp;
    logic s_ovf, s_unf;

    always #10 clk = ~clk;   // 50 MHz

    rwin_regfile #(.NWIN(NW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .rs1_addr    (rs1_addr),
        .rs1_data    (rs1_data),
        .rs2_addr    (rs2_addr),
        .rs2_data    (rs2_data),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .save_req    (save_req),
        .restore_req (restore_req),
        .alt_glob    (alt_glob),
        .win_invalid (win_invalid),
        .cwp         (cwp),
        .ovf         (ovf),
        .unf         (unf)
    );

    function automatic int dn(int w); return (w + NW - 1) % NW; endfunction
    function automatic int up(int w); return (w + 1) % NW; endfunction

    function automatic logic [63:0] mread(logic [4:0] a, logic alt);
        int i = int'(a[2:0]);
        if (a == 5'd0) return 64'd0;
        case (a[4:3])
            2'd0:    return alt ? m_alt[i] : m_glob[i];
            2'd1:    return m_in[dn(m_cwp)][i];
            2'd2:    return m_loc[m_cwp][i];
            default: return m_in[m_cwp][i];
        endcase
    endfunction

    function automatic string rtag(logic [4:0] a);
        if (a == 5'd0) return "R2";
        case (a[4:3])
            2'd0:    return "R10";
            2'd1:    return "R8";
            2'd2:    return "R9";
            default: return "R3";
        endcase
    endfunction

    task automatic mwrite(logic [4:0] a, logic [63:0] v, logic alt);
        int i = int'(a[2:0]);
        if (a == 5'd0) return;
        case (a[4:3])
            2'd0:    if (alt) m_alt[i] = v; else m_glob[i] = v;
            2'd1:    m_in[dn(m_cwp)][i] = v;
            2'd2:    m_loc[m_cwp][i] = v;
            default: m_in[m_cwp][i] = v;
        endcase
    endtask

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cwp = 0;
        for (int i = 0; i < 8; i++) begin
            m_glob[i] = '0;
            m_alt[i]  = '0;
            for (int w = 0; w < NW; w++) begin
                m_in[w][i]  = '0;
                m_loc[w][i] = '0;
            end
        end
    endtask

    // One cycle: drive at negedge, check before posedge, update model at posedge
    task automatic step(logic sv, logic rs, logic we, logic alt,
                        logic [4:0] a1, logic [4:0] a2, logic [4:0] wa,
                        logic [63:0] wd, logic [NW-1:0] wim);
        logic e_ovf, e_unf;
        @(negedge clk);
        save_req = sv; restore_req = rs; wr_en = we; alt_glob = alt;
        rs1_addr = a1; rs2_addr = a2; wr_addr = wa; wr_data = wd;
        win_invalid = wim;
        #1;
        e_ovf = sv && !rs && wim[dn(m_cwp)];
        e_unf = rs && !sv && wim[up(m_cwp)];
        s_rd1 = rs1_data; s_rd2 = rs2_data; s_cwp = cwp; s_ovf = ovf; s_unf = unf;
        chk(rtag(a1), rs1_data, mread(a1, alt));
        chk(rtag(a2), rs2_data, mread(a2, alt));
        chk("R4", 64'(cwp), 64'(m_cwp));
        chk("R5", 64'(ovf), 64'(e_ovf));
        chk("R6", 64'(unf), 64'(e_unf));
        @(posedge clk);
        if (we) mwrite(wa, wd, alt);      // R11: pre-rotation mapping
        if (sv && !rs && !e_ovf) m_cwp = dn(m_cwp);
        if (rs && !sv && !e_unf) m_cwp = up(m_cwp);
    endtask

    task automatic rd(logic alt, logic [4:0] a1, logic [4:0] a2);
        step(1'b0, 1'b0, 1'b0, alt, a1, a2, 5'd0, 64'd0, '0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1;
        save_req = 0; restore_req = 0; wr_en = 0; alt_glob = 0;
        rs1_addr = 0; rs2_addr = 0; wr_addr = 0; wr_data = 0; win_invalid = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 cwp in reset", 64'(cwp), 64'd0);
        rst = 1'b0;

        // R1: everything reads zero after reset
        rd(1'b0, 5'd9, 5'd31);
        chk("R1 out reg", s_rd1, 64'd0);
        chk("R1 flags", {62'd0, s_ovf, s_unf}, 64'd0);
        rd(1'b1, 5'd5, 5'd20);

        // R2: write to register 0 is dropped
        step(0, 0, 1, 0, 5'd0, 5'd0, 5'd0, 64'hFFFF_FFFF_FFFF_FFFF, '0);
        rd(1'b0, 5'd0, 5'd0);
        chk("R2 x0 read", s_rd1, 64'd0);

        // R3: same-cycle read of written register returns old value
        step(0, 0, 1, 0, 5'd20, 5'd20, 5'd20, 64'hAAAA_0000_0000_0001, '0);
        chk("R3 old value", s_rd1, 64'd0);
        rd(1'b0, 5'd20, 5'd0);
        chk("R3 new value", s_rd1, 64'hAAAA_0000_0000_0001);

        // R8 / R4: outs become ins after save, with wrap 0 -> NW-1
        step(0, 0, 1, 0, 5'd0, 5'd0, 5'd10, 64'hC0FF_EE00_0000_000A, '0);
        step(1, 0, 0, 0, 5'd0, 5'd0, 5'd0, 64'd0, '0);
        rd(1'b0, 5'd26, 5'd20);
        chk("R4 wrap down", 64'(s_cwp), 64'(NW - 1));
        chk("R8 out->in", s_rd1, 64'hC0FF_EE00_0000_000A);
        chk("R9 local private", s_rd2, 64'd0);

        // R4 restore wrap NW-1 -> 0, R9 local visible again
        step(0, 1, 0, 0, 5'd0, 5'd0, 5'd0, 64'd0, '0);
        rd(1'b0, 5'd20, 5'd10);
        chk("R4 wrap up", 64'(s_cwp), 64'd0);
        chk("R9 local back", s_rd1, 64'hAAAA_0000_0000_0001);
        chk("R8 in->out", s_rd2, 64'hC0FF_EE00_0000_000A);

        // R11: write together with save lands in pre-rotation outs
        step(1, 0, 1, 0, 5'd0, 5'd0, 5'd12, 64'h1111_2222_3333_4444, '0);
        rd(1'b0, 5'd28, 5'd12);
        chk("R11 write before rotate", s_rd1, 64'h1111_2222_3333_4444);

        // R7: both strobes -> no move, no flags
        step(1, 1, 0, 0, 5'd0, 5'd0, 5'd0, 64'd0, '1);
        chk("R7 no flags", {62'd0, s_ovf, s_unf}, 64'd0);
        rd(1'b0, 5'd0, 5'd0);
        chk("R7 no move", 64'(s_cwp), 64'(NW - 1));

        // R5: save onto invalid window refused
        step(1, 0, 0, 0, 5'd0, 5'd0, 5'd0, 64'd0, NW'(1) << (NW - 2));
        chk("R5 ovf raised", 64'(s_ovf), 64'd1);
        rd(1'b0, 5'd0, 5'd0);
        chk("R5 cwp held", 64'(s_cwp), 64'(NW - 1));

        // R6: restore onto invalid window refused
        step(0, 1, 0, 0, 5'd0, 5'd0, 5'd0, 64'd0, NW'(1));
        chk("R6 unf raised", 64'(s_unf), 64'd1);
        rd(1'b0, 5'd0, 5'd0);
        chk("R6 cwp held", 64'(s_cwp), 64'(NW - 1));

        // R10: normal vs alternate globals, shared across windows
        step(0, 0, 1, 0, 5'd0, 5'd0, 5'd3, 64'hD0D0_D0D0_0000_0003, '0);
        step(0, 0, 1, 1, 5'd0, 5'd0, 5'd3, 64'hE1E1_E1E1_0000_0003, '0);
        rd(1'b0, 5'd3, 5'd0);
        chk("R10 normal bank", s_rd1, 64'hD0D0_D0D0_0000_0003);
        rd(1'b1, 5'd3, 5'd0);
        chk("R10 alt bank", s_rd1, 64'hE1E1_E1E1_0000_0003);
        step(1, 0, 0, 0, 5'd0, 5'd0, 5'd0, 64'd0, '0);
        rd(1'b0, 5'd3, 5'd0);
        chk("R10 global shared", s_rd1, 64'hD0D0_D0D0_0000_0003);

        // Constrained random traffic against the model
        for (int n = 0; n < NRND; n++) begin
            int r = int'($urandom % 12);
            logic sv = (r < 2) || (r == 11);
            logic rs = (r == 2) || (r == 3) || (r == 11);
            logic [NW-1:0] wim = ($urandom % 4 == 0) ? NW'($urandom) : '0;
            logic [63:0] wd = {$urandom, $urandom};
            step(sv, rs, 1'($urandom), 1'($urandom % 4 == 0),
                 5'($urandom), 5'($urandom), 5'($urandom), wd, wim);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule